// File: doc/BRIEF.md
# TDM Frame Detector and Strobe Generator

This block sits beside a pair of serial ports. It watches an active-low frame-pulse input, sampled on a 4.096 MHz bit-rate clock, and decides from the shape of that signal whether the ports run on a framed time-division bus or as a plain synchronous serial port. A frame lasts 512 clocks (8 kHz). When the input carries single-clock low pulses, the block locks to them. When the input is tied low, it stays in the plain serial mode.

Once locked, a free-running frame-position counter drives all outputs. These are a half-rate bit clock for codec timing pins, two channel output-enable strobes, and a window that marks the timeslot carrying the compressed data. A position-select input moves both strobes and the compressed-data window to an alternate pair of timeslots. In plain serial mode every timing output stays low and the select input has no effect.

The frame position of a clock cycle is the number of clock edges since the edge that sampled a pulse's low level, taken modulo 512. Timeslot number = position / 16.

Top module: `tdm_strobe_gen`

## Requirements
- R1: While reset is asserted, and directly after it, `tdm_mode`, `clk2_o`, `ch1_en`, `ch2_en` and `cw_win` are all 0.
- R2: A valid pulse is exactly one low sample of `fp_n` with a high sample directly before and after it. `tdm_mode` rises after the edge that samples the high level ending a valid pulse, when that pulse's low sample lies exactly 512 edges after the low sample of the previous valid pulse. Low pulses two or more samples wide never count.
- R3: When `fp_n` has been sampled low on more than 512 consecutive edges, `tdm_mode` is 0 after that edge. It stays 0 until R2 is met again with two fresh pulses.
- R4: In TDM mode, a valid pulse whose low sample is not on frame position 0 clears `tdm_mode` and restarts position counting from that pulse. A later pulse 512 edges after it locks again.
- R5: In TDM mode, `clk2_o` is 1 at even frame positions and 0 at odd ones, so it toggles on every clock.
- R6: In TDM mode, `ch1_en` is 1 exactly during timeslot 0 when `pos_sel` = 1, and during timeslot 2 when `pos_sel` = 0. That is 16 clocks per frame.
- R7: In TDM mode, `ch2_en` is 1 exactly during timeslot 1 when `pos_sel` = 1, and during timeslot 3 when `pos_sel` = 0. That is 16 clocks per frame.
- R8: In TDM mode, `cw_win` is 1 exactly during timeslot 8 when `pos_sel` = 1, and during timeslot 10 when `pos_sel` = 0. It never overlaps a channel strobe.
- R9: When `tdm_mode` is 0, `clk2_o`, `ch1_en`, `ch2_en` and `cw_win` stay 0 whatever `pos_sel` does.
- R10: In TDM mode, frames with no pulse at all (`fp_n` held high) keep `tdm_mode` at 1, and the position count continues without a break.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 4.096 MHz bit-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fp_n | input | 1 | Active-low frame pulse, or tied low for plain serial mode |
| pos_sel | input | 1 | 1 = primary timeslots, 0 = alternate timeslots |
| tdm_mode | output | 1 | 1 while locked to framed bus timing |
| clk2_o | output | 1 | Half-rate clock aligned to the frame |
| ch1_en | output | 1 | Channel 1 output-enable strobe |
| ch2_en | output | 1 | Channel 2 output-enable strobe |
| cw_win | output | 1 | Compressed-data timeslot window |

## Verification
Two events can land on the same clock cycle. In the first, a frame pulse arrives while a strobe or the window is active: a misplaced pulse must drop the lock and silence that strobe in the very next cycle, while a correctly placed pulse must leave the strobe sequence unbroken. In the second, `pos_sel` flips in the middle of an active strobe, which must move the strobe at once. Random frames mix good, missing, misplaced and wide pulses, and `pos_sel` flips at random mid-frame points. Every cycle is judged against a cycle model of the requirements, tagged by output.

// File: rtl/tdm_sg_pkg.sv
package tdm_sg_pkg;

    typedef enum logic [1:0] {
        SYNC_IDLE   = 2'd0,
        SYNC_ARMED  = 2'd1,
        SYNC_LOCKED = 2'd2
    } sync_mode_e;

    localparam int NUM_LANES = 3;
    localparam int LANE_CH1  = 0;
    localparam int LANE_CH2  = 1;
    localparam int LANE_CW   = 2;

endpackage

// File: rtl/tdm_frame_sync.sv
module tdm_frame_sync
    import tdm_sg_pkg::*;
#(
    parameter int FRAME_LEN = 512,
    parameter int POS_W     = $clog2(FRAME_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fp_n,
    output logic [POS_W-1:0] frame_pos,
    output logic             locked
);

    localparam int LOW_W = $clog2(FRAME_LEN + 1);
    localparam logic [POS_W-1:0] POS_LAST = POS_W'(FRAME_LEN - 1);
    localparam logic [LOW_W-1:0] LOW_MAX  = LOW_W'(FRAME_LEN);

    typedef struct packed {
        logic             fp_q1;
        logic             fp_q2;
        logic [POS_W-1:0] pos;
        logic [LOW_W-1:0] low_cnt;
        sync_mode_e       mode;
    } sync_state_t;

    localparam sync_state_t RST_STATE = '{
        fp_q1:   1'b1,
        fp_q2:   1'b1,
        pos:     '0,
        low_cnt: '0,
        mode:    SYNC_IDLE
    };

    sync_state_t q, d;
    logic pulse_ok;
    logic on_grid;
    logic long_low;

    always_comb begin
        d = q;
        d.fp_q1 = fp_n;
        d.fp_q2 = q.fp_q1;

        // free-running position, wraps each frame
        d.pos = (q.pos == POS_LAST) ? '0 : q.pos + POS_W'(1);

        // run length of consecutive low samples, saturating
        if (fp_n) begin
            d.low_cnt = '0;
        end else if (q.low_cnt != LOW_MAX) begin
            d.low_cnt = q.low_cnt + LOW_W'(1);
        end

        // one low sample framed by highs, confirmed on its trailing high
        pulse_ok = fp_n & ~q.fp_q1 & q.fp_q2;
        // previous sample sat on frame position 0
        on_grid  = (q.pos == '0);
        // this edge is the (FRAME_LEN+1)-th consecutive low sample
        long_low = ~fp_n & (q.low_cnt == LOW_MAX);

        if (pulse_ok) begin
            d.pos = POS_W'(1);
            unique case (q.mode)
                SYNC_IDLE:   d.mode = SYNC_ARMED;
                SYNC_ARMED:  d.mode = on_grid ? SYNC_LOCKED : SYNC_ARMED;
                SYNC_LOCKED: d.mode = on_grid ? SYNC_LOCKED : SYNC_ARMED;
                default:     d.mode = SYNC_IDLE;
            endcase
        end

        if (long_low) begin
            d.mode = SYNC_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= RST_STATE;
        end else begin
            q <= d;
        end
    end

    assign frame_pos = q.pos;
    assign locked    = (q.mode == SYNC_LOCKED);

endmodule

// File: rtl/tdm_lane_match.sv
module tdm_lane_match #(
    parameter int POS_W    = 9,
    parameter int SLOT_LEN = 16,
    parameter int PRI_SLOT = 0,
    parameter int ALT_SLOT = 2
) (
    input  logic [POS_W-1:0] frame_pos,
    input  logic             use_pri,
    input  logic             enable,
    output logic             hit
);

    localparam logic [POS_W-1:0] SLOT_DIV = POS_W'(SLOT_LEN);
    localparam logic [POS_W-1:0] PRI_IDX  = POS_W'(PRI_SLOT);
    localparam logic [POS_W-1:0] ALT_IDX  = POS_W'(ALT_SLOT);

    logic [POS_W-1:0] slot_idx;

    always_comb begin
        slot_idx = frame_pos / SLOT_DIV;
        hit      = enable & (slot_idx == (use_pri ? PRI_IDX : ALT_IDX));
    end

endmodule

// File: rtl/tdm_slot_decode.sv
module tdm_slot_decode
    import tdm_sg_pkg::*;
#(
    parameter int POS_W    = 9,
    parameter int SLOT_LEN = 16,
    parameter int CH1_PRI  = 0,
    parameter int CH1_ALT  = 2,
    parameter int CH2_PRI  = 1,
    parameter int CH2_ALT  = 3,
    parameter int CW_PRI   = 8,
    parameter int CW_ALT   = 10
) (
    input  logic                 locked,
    input  logic [POS_W-1:0]     frame_pos,
    input  logic                 pri_sel,
    output logic                 clk2_o,
    output logic [NUM_LANES-1:0] lane_en
);

    localparam int PRI_TAB [NUM_LANES] = '{CH1_PRI, CH2_PRI, CW_PRI};
    localparam int ALT_TAB [NUM_LANES] = '{CH1_ALT, CH2_ALT, CW_ALT};

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        tdm_lane_match #(
            .POS_W    (POS_W),
            .SLOT_LEN (SLOT_LEN),
            .PRI_SLOT (PRI_TAB[g]),
            .ALT_SLOT (ALT_TAB[g])
        ) u_match (
            .frame_pos (frame_pos),
            .use_pri   (pri_sel),
            .enable    (locked),
            .hit       (lane_en[g])
        );
    end

    // high on even positions: clk divided by two, phase tied to the frame
    assign clk2_o = locked & ~frame_pos[0];

endmodule

// File: rtl/tdm_strobe_gen.sv
module tdm_strobe_gen
    import tdm_sg_pkg::*;
#(
    parameter int FRAME_LEN = 512,
    parameter int SLOT_LEN  = 16,
    parameter int CH1_PRI   = 0,
    parameter int CH1_ALT   = 2,
    parameter int CH2_PRI   = 1,
    parameter int CH2_ALT   = 3,
    parameter int CW_PRI    = 8,
    parameter int CW_ALT    = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fp_n,
    input  logic pos_sel,
    output logic tdm_mode,
    output logic clk2_o,
    output logic ch1_en,
    output logic ch2_en,
    output logic cw_win
);

    localparam int POS_W = $clog2(FRAME_LEN);

    logic [POS_W-1:0]     frame_pos;
    logic                 locked;
    logic [NUM_LANES-1:0] lane_en;

    tdm_frame_sync #(
        .FRAME_LEN (FRAME_LEN),
        .POS_W     (POS_W)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .fp_n      (fp_n),
        .frame_pos (frame_pos),
        .locked    (locked)
    );

    tdm_slot_decode #(
        .POS_W    (POS_W),
        .SLOT_LEN (SLOT_LEN),
        .CH1_PRI  (CH1_PRI),
        .CH1_ALT  (CH1_ALT),
        .CH2_PRI  (CH2_PRI),
        .CH2_ALT  (CH2_ALT),
        .CW_PRI   (CW_PRI),
        .CW_ALT   (CW_ALT)
    ) u_decode (
        .locked    (locked),
        .frame_pos (frame_pos),
        .pri_sel   (pos_sel),
        .clk2_o    (clk2_o),
        .lane_en   (lane_en)
    );

    assign tdm_mode = locked;
    assign ch1_en   = lane_en[LANE_CH1];
    assign ch2_en   = lane_en[LANE_CH2];
    assign cw_win   = lane_en[LANE_CW];

endmodule

// File: rtl/tdm_strobe_gen_chk.sv
module tdm_strobe_gen_chk #(
    parameter int FRAME_LEN = 512
) (
    input logic clk,
    input logic rst_n,
    input logic fp_n,
    input logic tdm_mode,
    input logic clk2_o,
    input logic ch1_en,
    input logic ch2_en,
    input logic cw_win
);

    localparam int RUN_W = $clog2(FRAME_LEN + 2);
    localparam logic [RUN_W-1:0] RUN_CAP = RUN_W'(FRAME_LEN + 1);
    localparam logic [RUN_W-1:0] RUN_LIM = RUN_W'(FRAME_LEN);

    logic [RUN_W-1:0] low_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run <= '0;
        end else if (fp_n) begin
            low_run <= '0;
        end else if (low_run != RUN_CAP) begin
            low_run <= low_run + RUN_W'(1);
        end
    end

    // R2: lock only follows a one-sample low closed by a high sample
    a_r2_lock_after_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tdm_mode) |-> ($past(fp_n) && !$past(fp_n, 2)));

    // R3: more than a frame of low input forbids TDM mode
    a_r3_long_low_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (low_run > RUN_LIM) |-> !tdm_mode);

    // R5: half-rate clock toggles every cycle while locked
    a_r5_clk2_toggles: assert property (@(posedge clk) disable iff (!rst_n)
        (tdm_mode && $past(tdm_mode)) |-> (clk2_o != $past(clk2_o)));

    // R6/R7: channel strobes never coincide
    a_r6_strobes_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
        !(ch1_en && ch2_en));

    // R8: data window stays apart from channel strobes
    a_r8_window_apart: assert property (@(posedge clk) disable iff (!rst_n)
        !(cw_win && (ch1_en || ch2_en)));

    // R9: all timing outputs quiet outside TDM mode
    a_r9_ssi_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !tdm_mode |-> !(clk2_o || ch1_en || ch2_en || cw_win));

endmodule

bind tdm_strobe_gen tdm_strobe_gen_chk #(
    .FRAME_LEN (FRAME_LEN)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .fp_n     (fp_n),
    .tdm_mode (tdm_mode),
    .clk2_o   (clk2_o),
    .ch1_en   (ch1_en),
    .ch2_en   (ch2_en),
    .cw_win   (cw_win)
);

// File: tb/tdm_strobe_gen_bench.sv
module tdm_strobe_gen_bench;

    localparam int FRAME  = 512;
    localparam int SLOT   = 16;
    localparam int CLK_NS = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fp_n = 1'b1;
    logic pos_sel = 1'b1;
    logic tdm_mode, clk2_o, ch1_en, ch2_en, cw_win;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    // reference state built from the requirements
    int m_mode = 0;      // 0 idle, 1 armed, 2 locked
    int m_pos = 0;
    int m_low = 0;
    bit m_p1 = 1'b1;
    bit m_p2 = 1'b1;

    int run_len [3] = '{0, 0, 0};
    int last_len [3] = '{0, 0, 0};

    always #(CLK_NS / 2) clk = ~clk;

    tdm_strobe_gen u_tdm_strobe_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .fp_n     (fp_n),
        .pos_sel  (pos_sel),
        .tdm_mode (tdm_mode),
        .clk2_o   (clk2_o),
        .ch1_en   (ch1_en),
        .ch2_en   (ch2_en),
        .cw_win   (cw_win)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_pos = 0; m_low = 0; m_p1 = 1'b1; m_p2 = 1'b1;
        end else begin
            bit valid;
            bit too_low;
            int npos;
            valid   = fp_n && !m_p1 && m_p2;                  // R2 pulse shape
            too_low = !fp_n && (m_low >= FRAME);             // R3
            npos    = (m_pos + 1) % FRAME;                   // R10 flywheel
            if (valid) begin
                if (m_mode != 0 && m_pos == 0) m_mode = 2;   // R2 second aligned pulse
                else m_mode = 1;                             // R4 re-arm
                npos = 1;
            end
            if (too_low) m_mode = 0;
            m_low = fp_n ? 0 : ((m_low < FRAME) ? m_low + 1 : m_low);
            m_p2 = m_p1;
            m_p1 = fp_n;
            m_pos = npos;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s at %0t: actual=%0d expected=%0d", req, $time, act, exp);
        end
    endtask

    function automatic bit exp_lane(input int lane, input bit sel, input bit locked, input int pos);
        int pri [3] = '{0, 1, 8};
        int alt [3] = '{2, 3, 10};
        return locked && ((pos / SLOT) == (sel ? pri[lane] : alt[lane]));
    endfunction

    task automatic compare();
        bit t;
        bit act [3];
        t = (m_mode == 2);
        act[0] = ch1_en; act[1] = ch2_en; act[2] = cw_win;
        check(tdm_mode === t, "R2 tdm_mode", int'(tdm_mode), int'(t));
        check(clk2_o === (t && (m_pos % 2 == 0)), t ? "R5 clk2_o" : "R9 clk2_o",
              int'(clk2_o), int'(t && (m_pos % 2 == 0)));
        check(ch1_en === exp_lane(0, pos_sel, t, m_pos), t ? "R6 ch1_en" : "R9 ch1_en",
              int'(ch1_en), int'(exp_lane(0, pos_sel, t, m_pos)));
        check(ch2_en === exp_lane(1, pos_sel, t, m_pos), t ? "R7 ch2_en" : "R9 ch2_en",
              int'(ch2_en), int'(exp_lane(1, pos_sel, t, m_pos)));
        check(cw_win === exp_lane(2, pos_sel, t, m_pos), t ? "R8 cw_win" : "R9 cw_win",
              int'(cw_win), int'(exp_lane(2, pos_sel, t, m_pos)));
        for (int i = 0; i < 3; i++) begin
            if (act[i] === 1'b1) run_len[i]++;
            else if (run_len[i] != 0) begin
                last_len[i] = run_len[i];
                run_len[i] = 0;
            end
        end
    endtask

    task automatic step(input bit f, input bit s);
        @(negedge clk);
        compare();
        fp_n = f;
        pos_sel = s;
    endtask

    task automatic good_frame(input bit s);
        step(1'b0, s);
        repeat (FRAME - 1) step(1'b1, s);
    endtask

    task automatic lock_up(input bit s);
        step(1'b0, s);
        repeat (FRAME - 1) step(1'b1, s);
        step(1'b0, s);
        step(1'b1, s);
        step(1'b1, s);
    endtask

    initial begin
        bit pat [FRAME];
        void'($urandom(32'd20240611));

        // R1: reset state
        repeat (3) @(negedge clk);
        check(tdm_mode === 1'b0, "R1 tdm_mode in reset", int'(tdm_mode), 0);
        check({clk2_o, ch1_en, ch2_en, cw_win} === 4'b0, "R1 outputs in reset",
              int'({clk2_o, ch1_en, ch2_en, cw_win}), 0);
        rst_n = 1'b1;
        repeat (5) step(1'b1, 1'b1);
        check(tdm_mode === 1'b0, "R1 tdm_mode after reset", int'(tdm_mode), 0);

        // R2: wide pulses on a 512 grid never lock
        for (int k = 0; k < 3; k++) begin
            step(1'b0, 1'b1);
            step(1'b0, 1'b1);
            repeat (FRAME - 2) step(1'b1, 1'b1);
        end
        check(tdm_mode === 1'b0, "R2 wide pulses rejected", int'(tdm_mode), 0);

        // R2: two aligned single pulses lock
        lock_up(1'b1);
        check(tdm_mode === 1'b1, "R2 lock after second pulse", int'(tdm_mode), 1);
        repeat (FRAME - 3) step(1'b1, 1'b1);

        // R6/R7/R8 strobe lengths in both positions
        good_frame(1'b1);
        good_frame(1'b1);
        check(last_len[0] == SLOT, "R6 ch1 length primary", last_len[0], SLOT);
        check(last_len[1] == SLOT, "R7 ch2 length primary", last_len[1], SLOT);
        check(last_len[2] == SLOT, "R8 window length primary", last_len[2], SLOT);
        good_frame(1'b0);
        good_frame(1'b0);
        check(last_len[0] == SLOT, "R6 ch1 length alternate", last_len[0], SLOT);
        check(last_len[1] == SLOT, "R7 ch2 length alternate", last_len[1], SLOT);
        check(last_len[2] == SLOT, "R8 window length alternate", last_len[2], SLOT);

        // R10: missing pulses keep lock
        repeat (3 * FRAME) step(1'b1, 1'b1);
        check(tdm_mode === 1'b1, "R10 lock held without pulses", int'(tdm_mode), 1);

        // R4: misplaced pulse inside channel 1 strobe drops lock, then relocks
        good_frame(1'b1);
        step(1'b0, 1'b1);
        repeat (6) step(1'b1, 1'b1);
        step(1'b0, 1'b1);
        step(1'b1, 1'b1);
        step(1'b1, 1'b1);
        check(tdm_mode === 1'b0, "R4 misplaced pulse drops lock", int'(tdm_mode), 0);
        check(ch1_en === 1'b0, "R4 strobe cut by drop", int'(ch1_en), 0);
        repeat (FRAME - 3) step(1'b1, 1'b1);
        step(1'b0, 1'b1);
        step(1'b1, 1'b1);
        step(1'b1, 1'b1);
        check(tdm_mode === 1'b1, "R4 relock from misplaced pulse", int'(tdm_mode), 1);
        repeat (FRAME - 3) step(1'b1, 1'b1);

        // random frames: good, skipped, misplaced, wide; select flips mid-frame
        for (int fr = 0; fr < 40; fr++) begin
            int kind;
            int flip_at;
            bit s;
            kind = $urandom_range(0, 9);
            s = 1'($urandom_range(0, 1));
            flip_at = ($urandom_range(0, 3) == 0) ? $urandom_range(1, 200) : -1;
            for (int i = 0; i < FRAME; i++) pat[i] = 1'b1;
            if (kind != 6) pat[0] = 1'b0;
            if (kind == 7) pat[$urandom_range(2, FRAME - 2)] = 1'b0;
            if (kind == 8) pat[1] = 1'b0;
            for (int i = 0; i < FRAME; i++) begin
                if (i == flip_at) s = ~s;
                step(pat[i], s);
            end
        end

        // return to a clean lock before the long-low test
        lock_up(1'b1);
        repeat (FRAME - 3) step(1'b1, 1'b1);
        check(tdm_mode === 1'b1, "R2 relock before long low", int'(tdm_mode), 1);

        // R3: 512 low samples keep lock, the 513th drops it
        repeat (FRAME) step(1'b0, 1'b1);
        @(negedge clk);
        compare();
        check(tdm_mode === 1'b1, "R3 still locked at 512 lows", int'(tdm_mode), 1);
        fp_n = 1'b0;
        @(negedge clk);
        compare();
        check(tdm_mode === 1'b0, "R3 dropped after 513 lows", int'(tdm_mode), 0);

        // R9: plain serial mode with select toggling
        for (int i = 0; i < 300; i++) begin
            step(1'b0, 1'(i % 7 == 0));
            if (i % 50 == 0)
                check({clk2_o, ch1_en, ch2_en, cw_win} === 4'b0, "R9 quiet in serial mode",
                      int'({clk2_o, ch1_en, ch2_en, cw_win}), 0);
        end

        step(1'b0, 1'b1);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        #(CLK_NS * 200000);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired: actual=0 expected=1");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule